// File: doc/BRIEF.md
# SPI Increment-Echo Responder

This block is an SPI target that runs entirely on the serial clock supplied by the bus master. While the active-low select is held low, it takes one data bit per rising clock edge, most significant bit first, and assembles whole bytes. At the rising edge that carries the eighth bit of a byte, it adds one to that byte and stores the sum in a reply buffer. That sum is shifted back out on the data-out line, most significant bit first, during the next byte the master clocks. The reply therefore trails the request by one byte.

The most recently completed byte and a one-cycle completion pulse are brought out so that neighbouring logic can observe the traffic. Both are in the serial clock domain. No synchronizer is placed on the serial inputs, because the clock and the data come from the same master.

Top module: `spi_echo_responder`

## Requirements
- R1: While `rst_n` is low at a rising `sclk` edge, the reply buffer, the observed byte and the bit position are all cleared. After reset, `byte_done` is 0, `rx_byte` is 0x00, and the first reply byte returned is 0x00.
- R2: Data on `mosi` is sampled on rising `sclk` edges, most significant bit first. At the rising edge of the eighth bit, `rx_byte` takes the full eight-bit value, including that last bit.
- R3: The reply clocked out during byte N+1 equals received byte N plus exactly one. The reply goes out most significant bit first, and `miso` changes only on falling `sclk` edges while `cs_n` is low.
- R4: The increment wraps modulo 256, so a received 0xFF is answered with 0x00.
- R5: `byte_done` is high for exactly one `sclk` cycle, following the rising edge that samples the eighth bit of a byte. It is low at every other time.
- R6: A rising `sclk` edge with `cs_n` high returns the bit position to zero, and `miso` is held at 0 while `cs_n` is high. A byte cut short by `cs_n` going high does not change the reply buffer or `rx_byte`, and it raises no `byte_done` pulse.
- R7: Bytes sent back to back without gaps (for example "HELLO" and "ABCD") each update the reply buffer on their own eighth bit. Every reply in the stream is correct, with no cumulative slip.
- R8: The first reply bit of a byte comes straight from the reply buffer. It is valid at the first rising edge after `cs_n` goes low, and also at the first edge of each following byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the master; the only clock of the block |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising `sclk` |
| cs_n | input | 1 | Active-low select from the master |
| mosi | input | 1 | Serial data from the master, sampled on rising `sclk` |
| miso | output | 1 | Serial reply to the master, updated on falling `sclk`, 0 when deselected |
| rx_byte | output | 8 | Last fully received byte |
| byte_done | output | 1 | One-cycle pulse after the eighth bit of a byte is sampled |

## Verification
The bench streams "HELLO" and "ABCD" back to back. If the buffer were loaded on the ninth bit, or from the shift register before its last bit arrived, the replies would be shifted by one bit or incremented twice, and these streams expose both faults. A received 0xFF must come back as 0x00 and not as a nine-bit carry.

Two further cases are checked. A byte cut short by raising select must leave the buffer and `rx_byte` untouched. The first reply after reset must be 0x00, with its most significant bit present at the very first edge. A design that read the first bit from the not-yet-loaded shift register would instead return the previous byte's low bits.

// File: rtl/spi_echo_pkg.sv
// Package: spi_echo_pkg
// Shared sizing for the increment-echo responder.
// Assumes the word width is a power of two so the bit position wraps cleanly.
package spi_echo_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned POS_W  = $clog2(WORD_W);
endpackage

// File: rtl/spi_echo_bitpos.sv
// Module: spi_echo_bitpos
// Tracks the bit position inside the current byte and flags the final bit.
// Assumes: runs on rising sclk; cs_n high on any edge restarts the byte.
module spi_echo_bitpos #(
    parameter int unsigned WORD_W = spi_echo_pkg::WORD_W,
    parameter int unsigned POS_W  = spi_echo_pkg::POS_W
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cs_n,
    output logic first_bit,
    output logic last_bit,
    output logic byte_done
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

    logic [POS_W-1:0] pos;

    // Decode the start and the final bit of the byte in progress.
    always_comb begin
        first_bit = (pos == '0);
        last_bit  = !cs_n && (pos == LAST_POS);
    end

    // Advance the position per sampled bit; pulse at the end of a byte.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            pos       <= '0;
            byte_done <= 1'b0;
        end else if (cs_n) begin
            pos       <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= (pos == LAST_POS);
            pos       <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        end
    end

    // R6: an edge with select high leaves the position at zero.
    p_idle_clears_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> (pos == '0));

    // R5: completion pulse never lasts two cycles.
    p_done_single_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R5: a pulse only follows a sampled final bit with select low.
    p_done_cause_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(byte_done) |-> ($past(pos) == LAST_POS) && !$past(cs_n));
endmodule

// File: rtl/spi_echo_rx.sv
// Module: spi_echo_rx
// Assembles MSB-first bytes from mosi and loads the reply buffer with byte+1.
// Assumes: last_bit marks the rising edge carrying the eighth bit. The reply
// uses the fresh word (stored bits plus the current mosi bit), never the
// stale shift register.
module spi_echo_rx #(
    parameter int unsigned WORD_W = spi_echo_pkg::WORD_W
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              last_bit,
    output logic [WORD_W-1:0] rx_byte,
    output logic [WORD_W-1:0] reply_buf
);
    logic [WORD_W-2:0] held;
    logic [WORD_W-1:0] word_now;

    // Form the complete word including the bit being sampled now.
    always_comb word_now = {held, mosi};

    // Shift in one bit per edge; on the final bit capture and increment.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            held      <= '0;
            rx_byte   <= '0;
            reply_buf <= '0;
        end else if (!cs_n) begin
            held <= word_now[WORD_W-2:0];
            if (last_bit) begin
                rx_byte   <= word_now;
                reply_buf <= word_now + 1'b1;
            end
        end
    end

    // R6/R7: the reply buffer changes only on a byte's final bit.
    p_buf_hold_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        !last_bit |=> $stable(reply_buf));

    // R4: an all-ones byte is answered with zero.
    p_wrap_zero_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        (last_bit && (word_now == '1)) |=> (reply_buf == '0));
endmodule

// File: rtl/spi_echo_tx.sv
// Module: spi_echo_tx
// Drives the reply MSB first, updating on falling sclk.
// Assumes: at a byte start the shift register is not yet loaded, so the
// leading bit is taken straight from the buffer while the rest is preloaded.
module spi_echo_tx #(
    parameter int unsigned WORD_W = spi_echo_pkg::WORD_W
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              first_bit,
    input  logic [WORD_W-1:0] reply_buf,
    output logic              miso
);
    logic [WORD_W-1:0] shreg;
    logic              out_q;

    // Present the next reply bit on each falling edge.
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            shreg <= '0;
            out_q <= 1'b0;
        end else if (cs_n || first_bit) begin
            out_q <= reply_buf[WORD_W-1];
            shreg <= {reply_buf[WORD_W-2:0], 1'b0};
        end else begin
            out_q <= shreg[WORD_W-1];
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    // Gate the output low while the target is not selected.
    always_comb miso = cs_n ? 1'b0 : out_q;

    // R8: at a byte start the leading bit mirrors the buffer MSB.
    p_lead_bit_r8: assert property (@(negedge sclk) disable iff (!rst_n)
        (cs_n || first_bit) |=> (out_q == $past(reply_buf[WORD_W-1])));
endmodule

// File: rtl/spi_echo_responder.sv
// Module: spi_echo_responder
// SPI target (sample on rising, drive on falling) returning each byte + 1
// one byte later. Everything runs on the master's sclk; no synchronizers.
// Assumes: rst_n is applied with sclk running and cs_n high.
module spi_echo_responder (
    input  logic       sclk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    import spi_echo_pkg::*;

    logic              first_bit;
    logic              last_bit;
    logic [WORD_W-1:0] reply_buf;

    spi_echo_bitpos #(.WORD_W(WORD_W), .POS_W(POS_W)) u_pos (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .first_bit (first_bit),
        .last_bit  (last_bit),
        .byte_done (byte_done)
    );

    spi_echo_rx #(.WORD_W(WORD_W)) u_rx (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .last_bit  (last_bit),
        .rx_byte   (rx_byte),
        .reply_buf (reply_buf)
    );

    spi_echo_tx #(.WORD_W(WORD_W)) u_tx (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .first_bit (first_bit),
        .reply_buf (reply_buf),
        .miso      (miso)
    );
endmodule

// File: tb/spi_echo_responder_tb.sv
module spi_echo_responder_tb;
    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [7:0] rx_byte;
    logic       byte_done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    logic [7:0] model_buf;

    spi_echo_responder u_dut (
        .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .rx_byte(rx_byte), .byte_done(byte_done)
    );

    always #2 sclk = ~sclk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Clock one full byte as master; returns the reply, checks strobe and capture.
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge sclk); #1;
            cs_n = 1'b0;
            mosi = tx[i];
            rx[i] = miso;
            if (i == 3) check("R5 no strobe mid-byte", byte_done, 0);
        end
        @(posedge sclk); #1;
        check("R5 strobe after eighth bit", byte_done, 1);
        check("R2 rx_byte capture", rx_byte, tx);
    endtask

    task automatic end_frame;
        @(negedge sclk); #1;
        cs_n = 1'b1;
        mosi = 1'b0;
        check("R6 miso low when deselected", miso, 0);
        repeat (2) @(negedge sclk);
    endtask

    // Send a stream; every reply must be the model buffer, then byte+1 is stored.
    task automatic stream(input string s, input string req);
        logic [7:0] r;
        for (int k = 0; k < s.len(); k++) begin
            xfer(s[k], r);
            check(req, r, model_buf);
            model_buf = s[k] + 8'd1;
        end
        end_frame();
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(posedge sclk);
        #1;
        check("R1 byte_done in reset", byte_done, 0);
        check("R1 rx_byte in reset", rx_byte, 0);
        check("R6 miso idle in reset", miso, 0);
        @(negedge sclk); #1;
        rst_n = 1'b1;
        model_buf = 8'h00;
    endtask

    task automatic t_first_reply;
        logic [7:0] r;
        xfer(8'hC3, r);
        check("R1 R8 first reply is 00", r, 8'h00);
        model_buf = 8'hC4;
        xfer(8'h5A, r);
        check("R3 R8 reply C3+1", r, 8'hC4);
        model_buf = 8'h5B;
        end_frame();
    endtask

    task automatic t_wrap;
        logic [7:0] r;
        xfer(8'hFF, r);
        check("R3 reply before wrap", r, model_buf);
        xfer(8'h7F, r);
        check("R4 FF answered with 00", r, 8'h00);
        xfer(8'h00, r);
        check("R3 7F answered with 80", r, 8'h80);
        model_buf = 8'h01;
        end_frame();
    endtask

    task automatic t_abort;
        logic [7:0] r;
        logic [7:0] keep_rx;
        keep_rx = rx_byte;
        for (int i = 0; i < 3; i++) begin
            @(negedge sclk); #1;
            cs_n = 1'b0;
            mosi = 1'b1;
        end
        @(negedge sclk); #1;
        cs_n = 1'b1;
        check("R6 no strobe on cut byte", byte_done, 0);
        repeat (3) @(negedge sclk);
        #1;
        check("R6 rx_byte kept after cut byte", rx_byte, keep_rx);
        xfer(8'h3C, r);
        check("R6 reply buffer kept after cut byte", r, model_buf);
        model_buf = 8'h3D;
        xfer(8'h10, r);
        check("R6 R7 realigned after cut byte", r, 8'h3D);
        model_buf = 8'h11;
        end_frame();
    endtask

    initial begin
        t_reset();
        t_first_reply();
        stream("HELLO", "R7 HELLO reply");
        stream("ABCD", "R7 ABCD reply");
        t_wrap();
        t_abort();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule